// File: doc/BRIEF.md
# Protection Key Register File

This block holds a small set of memory protection keys. Each slot carries a valid flag, a key, and three access-disable flags covering read, write and execute. Software-visible moves reach a slot through an index that the datapath takes from a general register value, so both the write port and the read port take the slot number as an input rather than a fixed address.

A third port performs a content-addressed lookup. A translation presents its key, the class of the reference and the kind of access. The file returns whether a valid slot matched and that slot's disable flags. It also raises a key-miss or a key-permission fault signal, but only when key checking is enabled and translation is enabled for that reference class.

Every write that installs a valid key first clears the valid flag of any other slot that already holds that same valid key. The cleared slot keeps its other fields. At most one valid slot can therefore answer a lookup.

Top module: `pkey_file`

## Requirements
- R1: A synchronous active-high reset leaves every slot reading as all zeros, so a lookup of any key that has checking and translation enabled reports a key miss.
- R2: A write stores the word in the selected slot with bit 0 as valid, bit 1 as write-disable, bit 2 as read-disable, bit 3 as execute-disable and bits 25:8 as the key. From the next cycle, a read of that slot returns these fields and zeros in all other bits. Reads have no side effects.
- R3: A write whose valid bit is set clears the valid bit of every other slot that holds the same key with its valid bit set. Those slots keep their key and disable bits.
- R4: A write whose valid bit is clear stores the word and leaves every other slot unchanged, including valid slots with the same key.
- R5: When the slot being written is itself the one holding the matching key, the new word is stored intact.
- R6: A lookup that hits reports hit=1 and the matching slot's disable bits as {execute, read, write} on bits 2:0.
- R7: A permission fault is raised on a hit when the disable bit for the access kind is set. The access code is 0 for read (bit 2), 1 for write (bit 1) and 2 for execute (bit 3). Code 3 never raises a permission fault.
- R8: A miss fault is raised when no valid slot holds the key. Slots that are not valid never match. Miss and permission faults are never raised together.
- R9: With key checking disabled, neither fault is raised.
- R10: The class code gates faults by its own translation enable: 0 data uses the data enable, 1 instruction uses the instruction enable, 2 register stack uses the stack enable. Class 3 never faults.
- R11: A write to an index at or above the slot count is ignored entirely, including its uniqueness check. A read of such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Slot selected for writing |
| wr_data | input | WORD_W | Word to store |
| rd_idx | input | IDX_W | Slot selected for reading |
| rd_data | output | WORD_W | Contents of the read slot |
| lk_valid | input | 1 | Lookup request present |
| lk_key | input | KEY_W | Key presented by the translation |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| lk_cls | input | 2 | Reference class: 0 data, 1 instruction, 2 register stack, 3 none |
| en_dxl | input | 1 | Data translation enabled |
| en_ixl | input | 1 | Instruction translation enabled |
| en_sxl | input | 1 | Register-stack translation enabled |
| en_key | input | 1 | Key checking enabled |
| lk_hit | output | 1 | A valid slot matched the key |
| lk_dis | output | 3 | Matched slot's {execute, read, write} disable bits |
| miss_flt | output | 1 | Key-miss fault |
| perm_flt | output | 1 | Key-permission fault |

## Verification
The bench builds two instances. The first uses the defaults of 16 slots, 18-bit keys and 64-bit words, which covers uniqueness, self-overwrite, the permission mapping and the enable gating. The second uses 6 slots, so a 3-bit index can name slots 6 and 7, which do not exist. With this instance, an out-of-range write that repeats a resident key can be shown to leave that key valid, and a read of a missing slot can be shown to return zero.

// File: rtl/pkey_pkg.sv
package pkey_pkg;
   typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2, ACC_NONE = 2'd3} acc_e;
   typedef enum logic [1:0] {CLS_DATA = 2'd0, CLS_INSTR = 2'd1, CLS_STACK = 2'd2, CLS_NONE = 2'd3} cls_e;
   localparam int POS_V   = 0;
   localparam int POS_WD  = 1;
   localparam int POS_RD  = 2;
   localparam int POS_XD  = 3;
   localparam int KEY_LSB = 8;
endpackage

// File: rtl/pkey_match.sv
module pkey_match #(
   parameter int NUM_ENTRIES = 16,
   parameter int KEY_W       = 18
) (
   input  logic [NUM_ENTRIES-1:0]            valid,
   input  logic [NUM_ENTRIES-1:0][KEY_W-1:0] keys,
   input  logic [KEY_W-1:0]                  probe,
   output logic [NUM_ENTRIES-1:0]            hit
);
   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
      assign hit[i] = valid[i] && (keys[i] == probe);
   end
endmodule

// File: rtl/pkey_fault.sv
module pkey_fault
   import pkey_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       lk_valid,
   input  logic [1:0] lk_acc,
   input  logic [1:0] lk_cls,
   input  logic       en_dxl,
   input  logic       en_ixl,
   input  logic       en_sxl,
   input  logic       en_key,
   input  logic       hit,
   input  logic [2:0] dis,
   output logic       miss_flt,
   output logic       perm_flt
);
   logic xl_on;
   logic chk_on;
   logic dis_sel;

   always_comb begin
      unique case (cls_e'(lk_cls))
         CLS_DATA:  xl_on = en_dxl;
         CLS_INSTR: xl_on = en_ixl;
         CLS_STACK: xl_on = en_sxl;
         default:   xl_on = 1'b0;
      endcase
      unique case (acc_e'(lk_acc))
         ACC_READ:  dis_sel = dis[1];
         ACC_WRITE: dis_sel = dis[0];
         ACC_EXEC:  dis_sel = dis[2];
         default:   dis_sel = 1'b0;
      endcase
   end

   assign chk_on   = lk_valid && en_key && xl_on;
   assign miss_flt = chk_on && !hit;
   assign perm_flt = chk_on && hit && dis_sel;

   // R9
   key_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !en_key |-> !miss_flt && !perm_flt);
   // R8
   fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(miss_flt && perm_flt));
   // R10
   cls_none_chk: assert property (@(posedge clk) disable iff (rst)
      lk_cls == 2'd3 |-> !miss_flt && !perm_flt);
endmodule

// File: rtl/pkey_file.sv
module pkey_file
   import pkey_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int KEY_W       = 18,
   parameter int WORD_W      = 64,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data,
   input  logic              lk_valid,
   input  logic [KEY_W-1:0]  lk_key,
   input  logic [1:0]        lk_acc,
   input  logic [1:0]        lk_cls,
   input  logic              en_dxl,
   input  logic              en_ixl,
   input  logic              en_sxl,
   input  logic              en_key,
   output logic              lk_hit,
   output logic [2:0]        lk_dis,
   output logic              miss_flt,
   output logic              perm_flt
);
   if (KEY_LSB + KEY_W > WORD_W) begin : g_bad_width
      $error("pkey_file: key field does not fit in WORD_W");
   end
   if (NUM_ENTRIES < 1) begin : g_bad_depth
      $error("pkey_file: NUM_ENTRIES must be positive");
   end

   logic [NUM_ENTRIES-1:0]            v_q, wd_q, rd_q, xd_q;
   logic [NUM_ENTRIES-1:0][KEY_W-1:0] key_q;
   logic [NUM_ENTRIES-1:0]            wr_hit, lk_vec;
   logic [KEY_W-1:0]                  wr_key;
   logic                              wr_ok, rd_ok;
   logic                              unused_bits;

   assign wr_key      = wr_data[KEY_LSB +: KEY_W];
   assign wr_ok       = wr_en && (32'(wr_idx) < NUM_ENTRIES);
   assign rd_ok       = 32'(rd_idx) < NUM_ENTRIES;
   assign unused_bits = ^wr_data;

   pkey_match #(.NUM_ENTRIES(NUM_ENTRIES), .KEY_W(KEY_W)) u_wr_match (
      .valid(v_q), .keys(key_q), .probe(wr_key), .hit(wr_hit));

   pkey_match #(.NUM_ENTRIES(NUM_ENTRIES), .KEY_W(KEY_W)) u_lk_match (
      .valid(v_q), .keys(key_q), .probe(lk_key), .hit(lk_vec));

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
      logic sel, kill;
      assign sel  = wr_ok && (wr_idx == IDX_W'(i));
      assign kill = wr_ok && wr_data[POS_V] && wr_hit[i];

      always_ff @(posedge clk) begin
         if (rst) begin
            v_q[i]   <= 1'b0;
            wd_q[i]  <= 1'b0;
            rd_q[i]  <= 1'b0;
            xd_q[i]  <= 1'b0;
            key_q[i] <= '0;
         end else if (sel) begin
            v_q[i]   <= wr_data[POS_V];
            wd_q[i]  <= wr_data[POS_WD];
            rd_q[i]  <= wr_data[POS_RD];
            xd_q[i]  <= wr_data[POS_XD];
            key_q[i] <= wr_key;
         end else if (kill) begin
            v_q[i]   <= 1'b0;
         end
      end

      // R3
      kill_keep_chk: assert property (@(posedge clk) disable iff (rst)
         kill && !sel |=> !v_q[i] && key_q[i] == $past(key_q[i])
                          && {xd_q[i], rd_q[i], wd_q[i]} == $past({xd_q[i], rd_q[i], wd_q[i]}));
      // R4
      clear_write_chk: assert property (@(posedge clk) disable iff (rst)
         wr_en && !wr_data[POS_V] && !sel |=> v_q[i] == $past(v_q[i]));
   end

   always_comb begin
      rd_data = '0;
      if (rd_ok) begin
         rd_data[POS_V]            = v_q[rd_idx];
         rd_data[POS_WD]           = wd_q[rd_idx];
         rd_data[POS_RD]           = rd_q[rd_idx];
         rd_data[POS_XD]           = xd_q[rd_idx];
         rd_data[KEY_LSB +: KEY_W] = key_q[rd_idx];
      end
   end

   always_comb begin
      lk_dis = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         lk_dis |= {xd_q[i], rd_q[i], wd_q[i]} & {3{lk_vec[i]}};
      end
   end
   assign lk_hit = |lk_vec;

   pkey_fault u_fault (
      .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_acc(lk_acc), .lk_cls(lk_cls),
      .en_dxl(en_dxl), .en_ixl(en_ixl), .en_sxl(en_sxl), .en_key(en_key),
      .hit(lk_hit), .dis(lk_dis), .miss_flt(miss_flt), .perm_flt(perm_flt));

   // R3
   key_unique_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(lk_vec));
   // R2
   wr_land_chk: assert property (@(posedge clk) disable iff (rst)
      wr_ok |=> v_q[$past(wr_idx)] == $past(wr_data[POS_V])
                && key_q[$past(wr_idx)] == $past(wr_key));
   // R11
   range_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en && !wr_ok |=> v_q == $past(v_q) && key_q == $past(key_q));
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> v_q == '0);
endmodule

// File: tb/pkey_file_tb.sv
module pkey_file_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0, wr_en_s = 1'b0;
   logic [3:0]  wr_idx = '0, rd_idx = '0;
   logic [2:0]  wr_idx_s = '0, rd_idx_s = '0;
   logic [63:0] wr_data = '0;
   logic [63:0] rd_data, rd_data_s;
   logic        lk_valid = 1'b1;
   logic [17:0] lk_key = '0;
   logic [1:0]  lk_acc = '0, lk_cls = '0;
   logic        en_dxl = 1'b1, en_ixl = 1'b1, en_sxl = 1'b1, en_key = 1'b1;
   logic        lk_hit, miss_flt, perm_flt, lk_hit_s, miss_s, perm_s;
   logic [2:0]  lk_dis, lk_dis_s;
   int          nchk = 0, nerr = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   pkey_file u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .lk_valid(lk_valid), .lk_key(lk_key),
      .lk_acc(lk_acc), .lk_cls(lk_cls), .en_dxl(en_dxl), .en_ixl(en_ixl),
      .en_sxl(en_sxl), .en_key(en_key), .lk_hit(lk_hit), .lk_dis(lk_dis),
      .miss_flt(miss_flt), .perm_flt(perm_flt));

   pkey_file #(.NUM_ENTRIES(6)) u_dut_small (
      .clk(clk), .rst(rst), .wr_en(wr_en_s), .wr_idx(wr_idx_s), .wr_data(wr_data),
      .rd_idx(rd_idx_s), .rd_data(rd_data_s), .lk_valid(lk_valid), .lk_key(lk_key),
      .lk_acc(lk_acc), .lk_cls(lk_cls), .en_dxl(en_dxl), .en_ixl(en_ixl),
      .en_sxl(en_sxl), .en_key(en_key), .lk_hit(lk_hit_s), .lk_dis(lk_dis_s),
      .miss_flt(miss_s), .perm_flt(perm_s));

   localparam logic [17:0] KA = 18'h01234, K3 = 18'h2ABCD, K7 = 18'h3FFFF;
   localparam logic [17:0] KM = 18'h00777, KR = 18'h0BEEF;

   function automatic logic [63:0] mk(bit v, bit wd, bit rdd, bit xd, logic [17:0] k);
      return {38'b0, k, 4'b0, xd, rdd, wd, v};
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] idx, logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_s(logic [2:0] idx, logic [63:0] d);
      @(negedge clk);
      wr_en_s = 1'b1; wr_idx_s = idx; wr_data = d;
      @(negedge clk);
      wr_en_s = 1'b0;
   endtask

   task automatic rd(logic [3:0] idx, string req, logic [63:0] exp);
      rd_idx = idx; #1;
      check(req, rd_data, exp);
   endtask

   task automatic look(logic [17:0] k, logic [1:0] acc, logic [1:0] cls);
      lk_key = k; lk_acc = acc; lk_cls = cls; #1;
   endtask

   task automatic t_reset();
      for (int i = 0; i < 16; i++) rd(4'(i), "R1 reset slot", 64'h0);
      look(18'h0, 2'd0, 2'd0);
      check("R1 reset miss", {lk_hit, miss_flt, perm_flt}, 3'b010);
   endtask

   task automatic t_readwrite();
      wr(4'd3, mk(1, 1, 0, 1, K3) | 64'hFFFF_FFF0_0000_00F0);
      rd(4'd3, "R2 readback masks reserved", mk(1, 1, 0, 1, K3));
      rd(4'd3, "R2 second read unchanged", mk(1, 1, 0, 1, K3));
      rd(4'd4, "R2 other slot untouched", 64'h0);
   endtask

   task automatic t_unique();
      wr(4'd1, mk(1, 0, 1, 0, KA));
      wr(4'd2, mk(1, 1, 0, 0, KA));
      rd(4'd1, "R3 old slot invalidated, fields kept", mk(0, 0, 1, 0, KA));
      rd(4'd2, "R3 new slot stored", mk(1, 1, 0, 0, KA));
      look(KA, 2'd0, 2'd0);
      check("R6 hit with disables", {lk_hit, lk_dis, miss_flt, perm_flt}, 6'b1_001_00);
      look(KA, 2'd1, 2'd0);
      check("R7 write disable faults", {miss_flt, perm_flt}, 2'b01);
   endtask

   task automatic t_valid_clear();
      wr(4'd4, mk(0, 0, 0, 1, KA));
      rd(4'd2, "R4 valid twin survives", mk(1, 1, 0, 0, KA));
      rd(4'd4, "R4 invalid word stored", mk(0, 0, 0, 1, KA));
   endtask

   task automatic t_same_slot();
      wr(4'd2, mk(1, 0, 0, 1, KA));
      rd(4'd2, "R5 self overwrite keeps new word", mk(1, 0, 0, 1, KA));
      look(KA, 2'd2, 2'd1);
      check("R5 exec fault from new word", {lk_hit, perm_flt}, 2'b11);
      look(KA, 2'd1, 2'd0);
      check("R5 write allowed by new word", perm_flt, 1'b0);
   endtask

   task automatic t_perm_map();
      wr(4'd7, mk(1, 0, 1, 0, K7));
      look(K3, 2'd0, 2'd0);
      check("R7 read on K3", {lk_dis, perm_flt}, 4'b101_0);
      look(K3, 2'd1, 2'd0);
      check("R7 write on K3", perm_flt, 1'b1);
      look(K3, 2'd2, 2'd1);
      check("R7 exec on K3", perm_flt, 1'b1);
      look(K3, 2'd3, 2'd0);
      check("R7 access none on K3", {miss_flt, perm_flt}, 2'b00);
      look(K7, 2'd0, 2'd2);
      check("R7 read on K7", perm_flt, 1'b1);
      look(K7, 2'd1, 2'd2);
      check("R7 write on K7", perm_flt, 1'b0);
   endtask

   task automatic t_miss();
      wr(4'd6, mk(0, 0, 0, 0, KM));
      look(KM, 2'd0, 2'd0);
      check("R8 invalid slot does not match", {lk_hit, miss_flt, perm_flt}, 3'b010);
      look(18'h15555, 2'd1, 2'd0);
      check("R8 absent key misses", {lk_hit, miss_flt, perm_flt}, 3'b010);
   endtask

   task automatic t_gating();
      en_key = 1'b0;
      look(KM, 2'd0, 2'd0);
      check("R9 no miss when checking off", miss_flt, 1'b0);
      look(K3, 2'd1, 2'd0);
      check("R9 no perm when checking off", {lk_hit, perm_flt}, 2'b10);
      en_key = 1'b1; en_dxl = 1'b0;
      look(KM, 2'd0, 2'd0);
      check("R10 data class gated", miss_flt, 1'b0);
      look(KM, 2'd0, 2'd1);
      check("R10 instr class active", miss_flt, 1'b1);
      en_ixl = 1'b0;
      look(KM, 2'd0, 2'd1);
      check("R10 instr class gated", miss_flt, 1'b0);
      look(KM, 2'd0, 2'd2);
      check("R10 stack class active", miss_flt, 1'b1);
      en_sxl = 1'b0;
      look(KM, 2'd0, 2'd2);
      check("R10 stack class gated", miss_flt, 1'b0);
      en_dxl = 1'b1; en_ixl = 1'b1; en_sxl = 1'b1;
      look(KM, 2'd0, 2'd3);
      check("R10 class none", miss_flt, 1'b0);
   endtask

   task automatic t_range();
      wr_s(3'd0, mk(1, 0, 0, 0, KR));
      wr_s(3'd7, mk(1, 1, 1, 1, KR));
      rd_idx_s = 3'd7; #1;
      check("R11 missing slot reads zero", rd_data_s, 64'h0);
      rd_idx_s = 3'd0; #1;
      check("R11 resident key kept valid", rd_data_s, mk(1, 0, 0, 0, KR));
      look(KR, 2'd2, 2'd0);
      check("R11 lookup still hits slot 0", {lk_hit_s, lk_dis_s, perm_s}, 5'b1_000_0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_readwrite();
      t_unique();
      t_valid_clear();
      t_same_slot();
      t_perm_map();
      t_miss();
      t_gating();
      t_range();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule